// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Run-Time Write Policy

This block is a data cache that sits between a processor port and a block-oriented memory port. Every address is split into three fields: a tag in the upper bits, a set index in the middle and a word offset in the low bits. The set index picks one set of two lines, and a block may sit in either line. When both lines are occupied, the line that was used less recently is replaced. One bit per set records which line that is.

Two control inputs choose the operating policy while the block runs. `cfg_bypass` sends every access straight to memory. `cfg_wback` selects write-back when high and write-through when low. Two single-cycle commands act on the whole array. One simply drops every line. The other first copies each modified line out to memory and then drops it. While either command runs, the block raises `busy` and serves no processor request.

Memory traffic has three forms: block reads that fill a line, block writes that copy a modified line out, and single-word writes used for write-through and bypass writes. Each transfer holds `mem_req` until a one-cycle `mem_ack`.

Top module: `cache2w_top`

## Requirements
- R1: A read of a word whose block is resident returns the stored word with no memory transfer, and at most one way of a set ever matches a given tag.
- R2: A read miss with bypass off issues exactly one block read (mem_op 0) at the block-aligned address, with the word field zero. Word i of the block is carried on data bits [32*i +: 32]. Afterwards, reads of any word of that block hit.
- R3: A miss replaces the line of its set that was used less recently. Every hit and every fill marks the other way as the next victim.
- R4: With cfg_wback=1, a write hit updates only the cache, marks the line modified and causes no memory transfer.
- R5: A replaced line is copied out by one block write (mem_op 1) before the fill, but only if it is modified. A clean victim causes no block write.
- R6: With cfg_wback=0, every write issues one single-word write (mem_op 2, data on mem_wdata[31:0], full word address). A write hit also updates the cached copy. A write miss does not allocate a line.
- R7: With cfg_wback=1, a write miss fetches the block with one block read, then merges the new word into the line; it issues no single-word write.
- R8: With cfg_bypass=1, each read issues a block read and returns the addressed word, and each write issues a single-word write. No line is ever allocated.
- R9: A pulse on cmd_drop invalidates every line and writes nothing to memory, so modified data is discarded.
- R10: A pulse on cmd_clean writes each modified line to memory with a block write and then invalidates every line.
- R11: While a command runs, busy is high and cpu_ready stays low. A request held during that time is served after busy falls.
- R12: mem_req, mem_addr and mem_op hold steady until mem_ack, and cpu_ready is a single-cycle pulse.
- R13: After reset, busy, cpu_ready and mem_req are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | 1: all accesses go straight to memory |
| cfg_wback | input | 1 | 1: write-back, 0: write-through |
| cmd_drop | input | 1 | Pulse: invalidate all lines |
| cmd_clean | input | 1 | Pulse: write back modified lines, then invalidate all |
| busy | output | 1 | A command is being processed |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_op | output | 2 | 0 block read, 1 block write, 2 word write |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | DATA_W*2^WORD_W | Block write data, or word in the low bits |
| mem_rdata | input | DATA_W*2^WORD_W | Block read data |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The bench aims at replacement order within a set. It runs three blocks through the same set, so a design that marked the wrong way as next victim would fetch a block that should still hit. It also forces the eviction of a line that was modified and of one that was not: a missing copy-out leaves stale memory, and an extra one shows up as a surplus block write. Each run of a drop command is checked against a clean command, since a design that wrote back on drop, or lost dirty data on clean, shows the wrong memory contents afterwards. Bypass and write-through write misses are checked for a block that was silently allocated, which would turn the next read into a hit with no fetch. A random phase mixes all policies against a flat memory model.

// File: rtl/cache2w_pkg.sv
`timescale 1ns/1ps
package cache2w_pkg;
  typedef enum logic [1:0] {
    MOP_BLK_RD  = 2'd0,
    MOP_BLK_WR  = 2'd1,
    MOP_WORD_WR = 2'd2
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_EVICT, ST_FILL, ST_WORD, ST_BYPRD, ST_FLSCAN, ST_FLWB
  } ctl_st_e;
endpackage

// File: rtl/cache2w_array.sv
`timescale 1ns/1ps
module cache2w_array #(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 18,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic [1:0]        rd_valid,
  output logic [1:0]        rd_dirty,
  output logic [TAG_W-1:0]  rd_tag [2],
  output logic [LINE_W-1:0] rd_data [2],
  output logic              rd_lru,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_way,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              lru_en,
  input  logic [SET_W-1:0]  lru_set,
  input  logic              lru_val
);
  localparam int SETS = 1 << SET_W;

  // one bit per set: the way to replace next
  logic [SETS-1:0] lru_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[lru_set] <= lru_val;
  end
  assign rd_lru = lru_q[rd_set];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   dty_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [LINE_W-1:0] dat_q [SETS];
    logic              sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        dty_q <= '0;
      end else if (sel) begin
        vld_q[wr_set] <= wr_valid;
        dty_q[wr_set] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && wr_valid) begin
        tag_q[wr_set] <= wr_tag;
        dat_q[wr_set] <= wr_data;
      end
    end

    assign rd_valid[w] = vld_q[rd_set];
    assign rd_dirty[w] = dty_q[rd_set];
    assign rd_tag[w]   = tag_q[rd_set];
    assign rd_data[w]  = dat_q[rd_set];
  end
endmodule

// File: rtl/cache2w_ctrl.sv
`timescale 1ns/1ps
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 4,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32,
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W,
  localparam int LINE_W = DATA_W * (1 << WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bypass,
  input  logic              cfg_wback,
  input  logic              cmd_drop,
  input  logic              cmd_clean,
  output logic              busy,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [SET_W-1:0]  arr_set,
  input  logic [1:0]        arr_valid,
  input  logic [1:0]        arr_dirty,
  input  logic [TAG_W-1:0]  arr_tag [2],
  input  logic [LINE_W-1:0] arr_data [2],
  input  logic              arr_lru,
  output logic              wr_en,
  output logic [SET_W-1:0]  wr_set,
  output logic              wr_way,
  output logic              wr_valid,
  output logic              wr_dirty,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LINE_W-1:0] wr_data,
  output logic              lru_en,
  output logic [SET_W-1:0]  lru_set,
  output logic              lru_val,
  output logic              ev_hit,
  output logic              ev_hit_both,
  output logic              ev_wr_hit,
  output logic              ev_fill
);
  localparam logic [SET_W:0] FL_LAST = '1;

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[WORD_W +: SET_W];
  endfunction
  function automatic logic [WORD_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[WORD_W-1:0];
  endfunction
  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WORD_W-1:0] ix);
    return ln[ix*DATA_W +: DATA_W];
  endfunction
  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WORD_W-1:0] ix,
                                                 input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[ix*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  ctl_st_e           st;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic              way_q;
  logic [SET_W:0]    fl_idx;
  logic              fl_wb_q;
  logic              rdy_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  tag_a;
  logic [SET_W-1:0]  set_a;
  logic [WORD_W-1:0] word_a;
  logic              hit0, hit1, hway, victim;
  logic              fl_way, fl_needwb;
  logic [SET_W-1:0]  fl_set;

  assign tag_a  = f_tag(a_q);
  assign set_a  = f_set(a_q);
  assign word_a = f_word(a_q);
  assign fl_way = fl_idx[0];
  assign fl_set = fl_idx[SET_W:1];
  assign busy   = (st == ST_FLSCAN) || (st == ST_FLWB);
  assign arr_set = busy ? fl_set : set_a;

  assign hit0        = arr_valid[0] && (arr_tag[0] == tag_a);
  assign hit1        = arr_valid[1] && (arr_tag[1] == tag_a);
  assign hway        = hit1;
  assign victim      = arr_lru;
  assign ev_hit      = (st == ST_LOOK) && (hit0 || hit1);
  assign ev_hit_both = (st == ST_LOOK) && hit0 && hit1;
  assign ev_wr_hit   = ev_hit && we_q;
  assign ev_fill     = (st == ST_FILL) && mem_ack;
  assign fl_needwb   = fl_wb_q && arr_valid[fl_way] && arr_dirty[fl_way];

  assign cpu_ready = rdy_q;
  assign cpu_rdata = rdata_q;

  // memory port and array write port
  always_comb begin
    mem_req   = 1'b0;
    mem_op    = MOP_BLK_RD;
    mem_addr  = {tag_a, set_a, {WORD_W{1'b0}}};
    mem_wdata = '0;
    wr_en     = 1'b0;
    wr_set    = arr_set;
    wr_way    = way_q;
    wr_valid  = 1'b0;
    wr_dirty  = 1'b0;
    wr_tag    = tag_a;
    wr_data   = mem_rdata;
    lru_en    = 1'b0;
    lru_set   = set_a;
    lru_val   = 1'b0;
    case (st)
      ST_LOOK: if (ev_hit) begin
        lru_en  = 1'b1;
        lru_val = ~hway;
        if (we_q) begin
          wr_en    = 1'b1;
          wr_way   = hway;
          wr_valid = 1'b1;
          wr_dirty = arr_dirty[hway] | cfg_wback;
          wr_data  = put_word(arr_data[hway], word_a, wd_q);
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_op    = MOP_BLK_WR;
        mem_addr  = {arr_tag[way_q], set_a, {WORD_W{1'b0}}};
        mem_wdata = arr_data[way_q];
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          wr_en    = 1'b1;
          wr_valid = 1'b1;
          lru_en   = 1'b1;
          lru_val  = ~way_q;
        end
      end
      ST_BYPRD: mem_req = 1'b1;
      ST_WORD: begin
        mem_req   = 1'b1;
        mem_op    = MOP_WORD_WR;
        mem_addr  = a_q;
        mem_wdata = LINE_W'(wd_q);
      end
      ST_FLSCAN: if (!fl_needwb) begin
        wr_en  = 1'b1;
        wr_way = fl_way;
      end
      ST_FLWB: begin
        mem_req   = 1'b1;
        mem_op    = MOP_BLK_WR;
        mem_addr  = {arr_tag[fl_way], fl_set, {WORD_W{1'b0}}};
        mem_wdata = arr_data[fl_way];
        wr_en     = mem_ack;
        wr_way    = fl_way;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      a_q     <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      way_q   <= 1'b0;
      fl_idx  <= '0;
      fl_wb_q <= 1'b0;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdy_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_drop || cmd_clean) begin
            fl_wb_q <= cmd_clean;
            fl_idx  <= '0;
            st      <= ST_FLSCAN;
          end else if (cpu_req && !rdy_q) begin
            a_q  <= cpu_addr;
            we_q <= cpu_we;
            wd_q <= cpu_wdata;
            if (cfg_bypass) st <= cpu_we ? ST_WORD : ST_BYPRD;
            else            st <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (ev_hit) begin
            if (!we_q) rdata_q <= get_word(arr_data[hway], word_a);
            if (we_q && !cfg_wback) st <= ST_WORD;
            else begin
              rdy_q <= 1'b1;
              st    <= ST_IDLE;
            end
          end else if (we_q && !cfg_wback) begin
            st <= ST_WORD;
          end else begin
            way_q <= victim;
            st    <= (arr_valid[victim] && arr_dirty[victim]) ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack) st <= ST_FILL;
        ST_FILL:  if (mem_ack) st <= ST_LOOK;
        ST_WORD: if (mem_ack) begin
          rdy_q <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_BYPRD: if (mem_ack) begin
          rdata_q <= get_word(mem_rdata, word_a);
          rdy_q   <= 1'b1;
          st      <= ST_IDLE;
        end
        ST_FLSCAN: begin
          if (fl_needwb)              st <= ST_FLWB;
          else if (fl_idx == FL_LAST) st <= ST_IDLE;
          else                        fl_idx <= fl_idx + 1'b1;
        end
        ST_FLWB: if (mem_ack) begin
          if (fl_idx == FL_LAST) st <= ST_IDLE;
          else begin
            fl_idx <= fl_idx + 1'b1;
            st     <= ST_FLSCAN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_top.sv
`timescale 1ns/1ps
module cache2w_top #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 4,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32,
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W,
  localparam int LINE_W = DATA_W * (1 << WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bypass,
  input  logic              cfg_wback,
  input  logic              cmd_drop,
  input  logic              cmd_clean,
  output logic              busy,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [SET_W-1:0]  arr_set;
  logic [1:0]        arr_valid, arr_dirty;
  logic [TAG_W-1:0]  arr_tag [2];
  logic [LINE_W-1:0] arr_data [2];
  logic              arr_lru;
  logic              wr_en, wr_way, wr_valid, wr_dirty;
  logic [SET_W-1:0]  wr_set;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_data;
  logic              lru_en, lru_val;
  logic [SET_W-1:0]  lru_set;
  logic              ev_hit, ev_hit_both, ev_wr_hit, ev_fill;

  cache2w_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_wback(cfg_wback),
    .cmd_drop(cmd_drop), .cmd_clean(cmd_clean), .busy(busy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .arr_set(arr_set), .arr_valid(arr_valid), .arr_dirty(arr_dirty),
    .arr_tag(arr_tag), .arr_data(arr_data), .arr_lru(arr_lru),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_valid(wr_valid),
    .wr_dirty(wr_dirty), .wr_tag(wr_tag), .wr_data(wr_data),
    .lru_en(lru_en), .lru_set(lru_set), .lru_val(lru_val),
    .ev_hit(ev_hit), .ev_hit_both(ev_hit_both), .ev_wr_hit(ev_wr_hit), .ev_fill(ev_fill)
  );

  cache2w_array #(.SET_W(SET_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_set(arr_set),
    .rd_valid(arr_valid), .rd_dirty(arr_dirty), .rd_tag(arr_tag), .rd_data(arr_data),
    .rd_lru(arr_lru),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_valid(wr_valid),
    .wr_dirty(wr_dirty), .wr_tag(wr_tag), .wr_data(wr_data),
    .lru_en(lru_en), .lru_set(lru_set), .lru_val(lru_val)
  );
endmodule

// File: rtl/cache2w_chk.sv
`timescale 1ns/1ps
module cache2w_chk #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [1:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cfg_wback,
  input logic              cfg_bypass,
  input logic              ev_hit,
  input logic              ev_hit_both,
  input logic              ev_wr_hit,
  input logic              ev_fill
);
  p_single_way_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> !ev_hit_both);

  p_fill_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_op == 2'd0) |-> (mem_addr[WORD_W-1:0] == '0));

  p_wback_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_hit && cfg_wback) |=> !mem_req);

  p_wthru_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_hit && !cfg_wback) |=> (mem_req && mem_op == 2'd2));

  p_bypass_no_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |-> !cfg_bypass);

  p_busy_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cpu_ready);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_op)));

  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
endmodule

bind cache2w_top cache2w_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_op(mem_op), .mem_addr(mem_addr),
  .cfg_wback(cfg_wback), .cfg_bypass(cfg_bypass),
  .ev_hit(ev_hit), .ev_hit_both(ev_hit_both), .ev_wr_hit(ev_wr_hit), .ev_fill(ev_fill)
);

// File: tb/cache2w_top_tb.sv
`timescale 1ns/1ps
module cache2w_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bypass = 1'b0, cfg_wback = 1'b1, cmd_drop = 1'b0, cmd_clean = 1'b0;
  logic busy, cpu_req = 1'b0, cpu_we = 1'b0, cpu_ready;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [1:0] mem_op;
  logic [23:0] mem_addr;
  logic [127:0] mem_wdata, mem_rdata = '0;

  int total = 0, bad = 0;
  int n_brd = 0, n_bwr = 0, n_wwr = 0, hold_err = 0;
  logic [23:0] last_brd = '0;
  logic [31:0] mem_m [int];
  logic [31:0] gold [int];
  logic [23:0] m_a0;
  logic [1:0]  m_op0;

  always #5 clk = ~clk;

  cache2w_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_wback(cfg_wback),
    .cmd_drop(cmd_drop), .cmd_clean(cmd_clean), .busy(busy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // address built from tag, set and word with the default 18/4/2 split
  function automatic logic [23:0] mk(int t, int s, int w);
    return 24'((t << 6) | (s << 2) | w);
  endfunction
  function automatic logic [31:0] memval(int a);
    if (mem_m.exists(a)) return mem_m[a];
    return 32'(a) * 32'h9E3779B1 ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] expv(int a);
    if (gold.exists(a)) return gold[a];
    return memval(a);
  endfunction
  function automatic int traffic();
    return n_brd + n_bwr + n_wwr;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model: serves one transfer two cycles after it sees the request
  always begin
    @(negedge clk);
    if (rst_n && mem_req) begin
      m_a0 = mem_addr;
      m_op0 = mem_op;
      repeat (2) @(negedge clk);
      if (mem_addr !== m_a0 || mem_op !== m_op0 || !mem_req) hold_err++;
      case (m_op0)
        2'd0: begin
          for (int i = 0; i < 4; i++) mem_rdata[i*32 +: 32] = memval(int'(m_a0) + i);
          n_brd++;
          last_brd = m_a0;
        end
        2'd1: begin
          for (int i = 0; i < 4; i++) mem_m[int'(m_a0) + i] = mem_wdata[i*32 +: 32];
          n_bwr++;
        end
        default: begin
          mem_m[int'(m_a0)] = mem_wdata[31:0];
          n_wwr++;
        end
      endcase
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
    end
  end

  task automatic acc(input bit we, input logic [23:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    r = cpu_rdata;
    cpu_req = 1'b0;
    if (we) gold[int'(a)] = d;
  endtask

  task automatic rchk(input logic [23:0] a, input string req);
    logic [31:0] e, r;
    e = expv(int'(a));
    acc(1'b0, a, '0, r);
    check(r === e, req, r, e);
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    logic [31:0] r;
    acc(1'b1, a, d, r);
  endtask

  task automatic cmd(input bit clean, output int busy_cyc);
    @(negedge clk);
    if (clean) cmd_clean = 1'b1; else cmd_drop = 1'b1;
    @(negedge clk);
    cmd_clean = 1'b0; cmd_drop = 1'b0;
    busy_cyc = 0;
    while (busy) begin
      busy_cyc++;
      @(negedge clk);
    end
    if (!clean) gold.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R12 act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] A, A2, B, C, D, E;
    logic [31:0] r;
    int t, br, bw, ww, bc, seen;
    A = mk(1,1,2); A2 = mk(1,1,3); B = mk(2,1,0); C = mk(3,1,0);
    D = mk(0,2,1); E = mk(3,0,0);
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cpu_ready && !mem_req, "R13 reset outputs", {busy, cpu_ready, mem_req}, 0);

    // R2 / R13: first read misses and fills the aligned block
    br = n_brd; rchk(A, "R2 miss data");
    check(n_brd == br + 1, "R2 R13 one block read", n_brd - br, 1);
    check(last_brd == mk(1,1,0), "R2 aligned address", last_brd, mk(1,1,0));
    @(negedge clk);
    check(!cpu_ready, "R12 ready one cycle", cpu_ready, 0);
    t = traffic(); rchk(A2, "R1 hit data");
    check(traffic() == t, "R1 hit no traffic", traffic() - t, 0);

    // R3 replacement order within set 1
    rchk(B, "R3 fill B"); rchk(A, "R3 hit A");
    br = n_brd; bw = n_bwr; rchk(C, "R3 fill C");
    check(n_brd == br + 1 && n_bwr == bw, "R5 clean victim no write", n_bwr - bw, 0);
    t = traffic(); rchk(A, "R3 A kept");
    check(traffic() == t, "R3 recent line kept", traffic() - t, 0);
    br = n_brd; rchk(B, "R3 B refetch");
    check(n_brd == br + 1, "R3 older line replaced", n_brd - br, 1);

    // R4 write-back hit
    t = traffic(); wr(A, 32'hCAFE0001);
    check(traffic() == t, "R4 write hit quiet", traffic() - t, 0);
    rchk(A, "R4 cached write");
    check(memval(int'(A)) != 32'hCAFE0001, "R4 memory untouched", memval(int'(A)), 0);

    // R5 dirty victim copied out
    rchk(B, "R5 touch B");
    bw = n_bwr; rchk(C, "R5 fill C");
    check(n_bwr == bw + 1, "R5 dirty victim written", n_bwr - bw, 1);
    check(memval(int'(A)) == 32'hCAFE0001, "R5 victim data", memval(int'(A)), 32'hCAFE0001);

    // R7 write-back write miss allocates
    br = n_brd; ww = n_wwr; wr(D, 32'h0D0D0001);
    check(n_brd == br + 1 && n_wwr == ww, "R7 fetch on write miss", n_brd - br, 1);
    t = traffic(); rchk(D, "R7 merged word");
    check(traffic() == t, "R7 line allocated", traffic() - t, 0);

    // R10 clean command
    bw = n_bwr; cmd(1'b1, bc);
    check(bc > 0, "R11 busy seen", bc, 1);
    check(n_bwr == bw + 1, "R10 one dirty line written", n_bwr - bw, 1);
    check(memval(int'(D)) == 32'h0D0D0001, "R10 memory updated", memval(int'(D)), 32'h0D0D0001);
    br = n_brd; rchk(D, "R10 after clean");
    check(n_brd == br + 1, "R10 lines invalid", n_brd - br, 1);

    // R6 write-through
    cfg_wback = 1'b0;
    ww = n_wwr; wr(D, 32'h0D0D0002);
    check(n_wwr == ww + 1 && memval(int'(D)) == 32'h0D0D0002, "R6 write hit to memory", memval(int'(D)), 32'h0D0D0002);
    t = traffic(); rchk(D, "R6 cached copy");
    check(traffic() == t, "R6 hit updated in cache", traffic() - t, 0);
    ww = n_wwr; br = n_brd; wr(E, 32'hEEEE0001);
    check(n_wwr == ww + 1 && n_brd == br, "R6 write miss no fetch", n_brd - br, 0);
    br = n_brd; rchk(E, "R6 miss data");
    check(n_brd == br + 1, "R6 no allocate", n_brd - br, 1);

    // R9 drop command discards dirty data
    cfg_wback = 1'b1;
    rchk(D, "R9 hit D");
    t = traffic(); wr(D, 32'h0D0D0003);
    check(traffic() == t, "R4 dirty write quiet", traffic() - t, 0);
    bw = n_bwr; cmd(1'b0, bc);
    check(n_bwr == bw, "R9 no write on drop", n_bwr - bw, 0);
    acc(1'b0, D, '0, r);
    check(r == 32'h0D0D0002, "R9 dirty data dropped", r, 32'h0D0D0002);

    // R11 request held during a clean command
    wr(E, 32'hEEEE0002);
    @(negedge clk);
    cmd_clean = 1'b1;
    @(negedge clk);
    cmd_clean = 1'b0;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A;
    seen = 0; bc = 0;
    while (busy) begin
      if (cpu_ready) seen++;
      bc++;
      @(negedge clk);
    end
    check(seen == 0 && bc > 0, "R11 no ready while busy", seen, 0);
    while (!cpu_ready) @(negedge clk);
    check(cpu_rdata == expv(int'(A)), "R11 held request served", cpu_rdata, expv(int'(A)));
    cpu_req = 1'b0;
    check(memval(int'(E)) == 32'hEEEE0002, "R10 clean wrote E", memval(int'(E)), 32'hEEEE0002);

    // R8 bypass
    cmd(1'b1, bc);
    cfg_bypass = 1'b1;
    br = n_brd; rchk(A, "R8 bypass read"); rchk(A, "R8 bypass read again");
    check(n_brd == br + 2, "R8 every read fetched", n_brd - br, 2);
    ww = n_wwr; wr(A, 32'hA5A50001);
    check(n_wwr == ww + 1 && memval(int'(A)) == 32'hA5A50001, "R8 write to memory", memval(int'(A)), 32'hA5A50001);
    rchk(A, "R8 read back");
    cfg_bypass = 1'b0;
    br = n_brd; rchk(A, "R8 after bypass");
    check(n_brd == br + 1, "R8 nothing allocated", n_brd - br, 1);

    // random mix across all policies
    for (int i = 0; i < 400; i++) begin
      logic [23:0] ra;
      if (i % 50 == 0) begin
        cmd(1'b1, bc);
        cfg_bypass = ($urandom % 4) == 0;
        cfg_wback  = $urandom % 2;
      end
      ra = mk($urandom % 4, $urandom % 3, $urandom % 4);
      if ($urandom % 2) wr(ra, $urandom);
      else rchk(ra, "R1 R2 random read");
    end
    cmd(1'b1, bc);
    for (int t2 = 0; t2 < 4; t2++)
      for (int s = 0; s < 3; s++)
        for (int w = 0; w < 4; w++)
          check(memval(int'(mk(t2, s, w))) == expv(int'(mk(t2, s, w))), "R10 final memory image",
                memval(int'(mk(t2, s, w))), expv(int'(mk(t2, s, w))));
    check(hold_err == 0, "R12 request held until ack", hold_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule